// File: doc/BRIEF.md
# Timeslot-0 Register Message Channel

This block runs a low-rate control channel inside the first 8-bit slot of each frame of a 2048 kbit/s serial multiplex. One byte of the channel rides in every frame, so a two-byte message spans two consecutive frames (250 µs at the nominal rate). On the receive side the block assembles the slot byte of each frame and decodes it. A byte with its top bit clear names a register address. The byte in the next frame, with its top bit set, supplies seven data bits. Together they produce a one-cycle write strobe with address and data for a 64-entry register file that lives outside the block.

On the transmit side the block reports alarms. Each alarm source has a pending flag that is set by a pulse on its input. Pending alarms are sent one at a time, lowest index first. Each one goes out as an address byte that names the alarm register, followed in the next frame by a data byte that carries the one-hot position of the alarm. When nothing is pending the slot carries all ones, and outside the slot the serial output stays high.

The block runs on a fast system clock. A one-cycle bit strobe marks each bit time of the multiplex, and a frame marker, given together with the strobe, marks the first bit of timeslot 0.

Top module: `ts0_ctrl_link`

## Requirements
- R1: Receive slot bits are the 8 bit strobes beginning at the strobe that carries the frame marker. They assemble most significant bit (bit 7) first. No byte is assembled before the first frame marker after reset.
- R2: A received slot byte with bit 7 = 0 is an address byte. Bits 5:0 give the register address and bit 6 is ignored.
- R3: A received byte with bit 7 = 1 that arrives in the frame after an address byte raises wr_stb for exactly one clock, in the cycle after the strobe of the last slot bit. wr_addr carries the held address and wr_data carries bits 6:0. wr_addr and wr_data change only together with wr_stb.
- R4: A byte with bit 7 = 1 and no unused address before it (including the all-ones idle byte, and a second data byte after a completed write) is discarded, and no write occurs.
- R5: A second address byte before any data byte replaces the held address.
- R6: Bits outside timeslot 0 are ignored on input. ser_out is 1 from the ninth bit strobe of a frame until the next frame marker.
- R7: A pulse on alarm_set[i] makes alarm i pending. Its message is the byte {0, ALARM_ADDR} (0x05 by default), followed in the next frame by {1, one-hot of i}, that is 0x80 | (1 << i).
- R8: Among pending alarms the lowest index is sent first, and one whole two-frame message is sent before the next alarm is chosen. An alarm raised while a message is in flight waits for that message to finish.
- R9: A frame with no message to send carries 0xFF in timeslot 0.
- R10: The transmit slot byte leaves most significant bit first. Bit 7 appears on ser_out right after the strobe that carries the frame marker, and each later bit appears after the following strobe.
- R11: After reset ser_out = 1, wr_stb = 0, and no alarm is pending.
- R12: Pulsing an alarm that is already pending does not add a second message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One-cycle strobe per multiplex bit time |
| frame_start | input | 1 | Marks, with bit_en, the first bit of timeslot 0 |
| ser_in | input | 1 | Serial multiplex input |
| ser_out | output | 1 | Serial multiplex output (timeslot 0 content, high elsewhere) |
| alarm_set | input | ALARM_W | One-cycle pulses that make alarms pending |
| wr_addr | output | ADDR_W | Register address of the decoded write |
| wr_data | output | 7 | Seven data bits of the decoded write |
| wr_stb | output | 1 | One-cycle write strobe |

## Verification
The hardest situation to reach is an alarm that becomes pending while another alarm's message is half sent, with a lower index than an alarm still waiting. Here the ordering rule and the rule that a message must finish both decide the next byte. The stimulus pends alarms 5 and 6 together. After the frame that carries the address byte, it raises alarm 1, so the expected stream is the tail for alarm 5, then the whole message for alarm 1, then the message for 6. Receive corner cases come from whole frames with chosen slot bytes and random bits elsewhere: an address replaced by a second address, a data byte with no address before it, and a data byte repeated after a completed write.

// File: rtl/ts0_link_pkg.sv
package ts0_link_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned DATA_W    = BYTE_W - 1;
  localparam int unsigned SLOT_BITS = 8;

  typedef logic [BYTE_W-1:0] octet_t;

  localparam octet_t IDLE_OCTET = '1;

  typedef enum logic [1:0] {
    RX_NONE,
    RX_ADDR,
    RX_DATA
  } rx_kind_e;

  typedef enum logic {
    TX_HEAD,
    TX_TAIL
  } tx_phase_e;
endpackage

// File: rtl/ts0_link_timer.sv
module ts0_link_timer
  import ts0_link_pkg::*;
#(
  parameter  int unsigned FRAME_BITS = 256,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_start,
  output logic             frame_edge,
  output logic             slot_bit,
  output logic             slot_last,
  output logic [CNT_W-1:0] bit_pos
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(SLOT_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SLOT_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             synced_q, synced_d;
  logic [CNT_W-1:0] cur_idx;
  logic             in_window;

  // position of the bit being sampled at this strobe
  always_comb begin
    frame_edge = bit_en & frame_start;
    in_window  = synced_q && (cnt_q < SLOT_END);
    slot_bit   = frame_edge || (bit_en && in_window);
    cur_idx    = frame_start ? '0 : cnt_q;
    slot_last  = slot_bit && (cur_idx == LAST_IDX);
  end

  always_comb begin
    cnt_d    = cnt_q;
    synced_d = synced_q;
    if (frame_edge) begin
      cnt_d    = CNT_W'(1);
      synced_d = 1'b1;
    end else if (bit_en && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      synced_q <= synced_d;
    end
  end

  assign bit_pos = cnt_q;
endmodule

// File: rtl/ts0_link_rx.sv
module ts0_link_rx
  import ts0_link_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_bit,
  input  logic              slot_last,
  input  logic              ser_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [ADDR_W-1:0] hold_q, hold_d;
  logic              armed_q, armed_d;
  logic              stb_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  octet_t            octet;
  rx_kind_e          kind;

  // classify the byte completing at this strobe
  always_comb begin
    octet = {acc_q, ser_in};
    if (!slot_last)           kind = RX_NONE;
    else if (octet[BYTE_W-1]) kind = RX_DATA;
    else                      kind = RX_ADDR;
  end

  always_comb begin
    acc_d   = slot_bit ? {acc_q[DATA_W-2:0], ser_in} : acc_q;
    hold_d  = hold_q;
    armed_d = armed_q;
    stb_d   = 1'b0;
    addr_d  = wr_addr;
    data_d  = wr_data;
    case (kind)
      RX_ADDR: begin
        hold_d  = octet[ADDR_W-1:0];
        armed_d = 1'b1;
      end
      RX_DATA: begin
        if (armed_q) begin
          stb_d   = 1'b1;
          addr_d  = hold_q;
          data_d  = octet[DATA_W-1:0];
          armed_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      hold_q  <= '0;
      armed_q <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      acc_q   <= acc_d;
      hold_q  <= hold_d;
      armed_q <= armed_d;
      wr_stb  <= stb_d;
      if (stb_d) begin
        wr_addr <= addr_d;
        wr_data <= data_d;
      end
    end
  end
endmodule

// File: rtl/ts0_link_tx.sv
module ts0_link_tx
  import ts0_link_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 6,
  parameter int unsigned       ALARM_W    = 7,
  parameter logic [ADDR_W-1:0] ALARM_ADDR = 6'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               frame_edge,
  input  logic [ALARM_W-1:0] alarm_set,
  output logic               ser_out,
  output logic [ALARM_W-1:0] pending
);
  localparam octet_t HEAD_OCTET = {1'b0, DATA_W'(ALARM_ADDR)};

  logic [ALARM_W-1:0] pend_q, pend_d;
  logic [ALARM_W-1:0] sel_q, sel_d;
  logic [ALARM_W-1:0] pick, clr;
  tx_phase_e          phase_q, phase_d;
  octet_t             sreg_q, sreg_d;
  octet_t             next_octet;

  // isolate the lowest pending alarm
  assign pick = pend_q & (~pend_q + 1'b1);

  always_comb begin
    next_octet = IDLE_OCTET;
    phase_d    = phase_q;
    sel_d      = sel_q;
    clr        = '0;
    if (frame_edge) begin
      if (phase_q == TX_TAIL) begin
        next_octet = {1'b1, DATA_W'(sel_q)};
        phase_d    = TX_HEAD;
      end else if (|pend_q) begin
        next_octet = HEAD_OCTET;
        sel_d      = pick;
        clr        = pick;
        phase_d    = TX_TAIL;
      end
    end
  end

  always_comb begin
    pend_d = (pend_q & ~clr) | alarm_set;
    if (frame_edge)  sreg_d = next_octet;
    else if (bit_en) sreg_d = {sreg_q[BYTE_W-2:0], 1'b1};
    else             sreg_d = sreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      sel_q   <= '0;
      phase_q <= TX_HEAD;
      sreg_q  <= IDLE_OCTET;
    end else begin
      pend_q  <= pend_d;
      sel_q   <= sel_d;
      phase_q <= phase_d;
      sreg_q  <= sreg_d;
    end
  end

  assign ser_out = sreg_q[BYTE_W-1];
  assign pending = pend_q;
endmodule

// File: rtl/ts0_ctrl_link.sv
module ts0_ctrl_link
  import ts0_link_pkg::*;
#(
  parameter int unsigned       FRAME_BITS = 256,
  parameter int unsigned       ADDR_W     = 6,
  parameter int unsigned       ALARM_W    = 7,
  parameter logic [ADDR_W-1:0] ALARM_ADDR = 6'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               frame_start,
  input  logic               ser_in,
  output logic               ser_out,
  input  logic [ALARM_W-1:0] alarm_set,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_stb
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);

  logic [1:0]         rst_pipe;
  logic               rst_n_i;
  logic               frame_edge, slot_bit, slot_last;
  logic [CNT_W-1:0]   bit_pos;
  logic [ALARM_W-1:0] alarm_pending;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  ts0_link_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .bit_en     (bit_en),
    .frame_start(frame_start),
    .frame_edge (frame_edge),
    .slot_bit   (slot_bit),
    .slot_last  (slot_last),
    .bit_pos    (bit_pos)
  );

  ts0_link_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .slot_bit (slot_bit),
    .slot_last(slot_last),
    .ser_in   (ser_in),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  ts0_link_tx #(
    .ADDR_W    (ADDR_W),
    .ALARM_W   (ALARM_W),
    .ALARM_ADDR(ALARM_ADDR)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .bit_en    (bit_en),
    .frame_edge(frame_edge),
    .alarm_set (alarm_set),
    .ser_out   (ser_out),
    .pending   (alarm_pending)
  );
endmodule

// File: rtl/ts0_ctrl_link_chk.sv
module ts0_ctrl_link_chk #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned ALARM_W = 7,
  parameter int unsigned CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               bit_en,
  input logic               frame_start,
  input logic               ser_out,
  input logic [ALARM_W-1:0] alarm_set,
  input logic [ALARM_W-1:0] alarm_pending,
  input logic [CNT_W-1:0]   bit_pos,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [6:0]         wr_data,
  input logic               wr_stb
);
  // R3: a write strobe lasts one clock
  p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_stb |=> !wr_stb);

  // R3: a strobe follows a bit strobe that is not a frame marker
  p_stb_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_stb |-> $past(bit_en && !frame_start));

  // R3: address and data move only with the strobe
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

  // R6: output high beyond the slot
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (bit_pos > CNT_W'(8)) |-> ser_out);

  // R7: a raised alarm is pending on the next cycle
  p_alarm_pend_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (|alarm_set) |=> (|alarm_pending));

  // R10: frame marker restarts the bit position
  p_frame_pos_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (bit_en && frame_start) |=> (bit_pos == CNT_W'(1)));
endmodule

bind ts0_ctrl_link ts0_ctrl_link_chk #(
  .ADDR_W (ADDR_W),
  .ALARM_W(ALARM_W),
  .CNT_W  ($clog2(FRAME_BITS))
) u_chk (
  .clk          (clk),
  .rst_ok       (rst_n_i),
  .bit_en       (bit_en),
  .frame_start  (frame_start),
  .ser_out      (ser_out),
  .alarm_set    (alarm_set),
  .alarm_pending(alarm_pending),
  .bit_pos      (bit_pos),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_stb       (wr_stb)
);

// File: tb/ts0_ctrl_link_test.sv
module ts0_ctrl_link_test;
  localparam int FRAME_BITS = 256;
  localparam logic [7:0] HEAD = 8'h05;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       frame_start = 1'b0;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic [6:0] alarm_set = '0;
  logic [5:0] wr_addr;
  logic [6:0] wr_data;
  logic       wr_stb;

  int checks = 0;
  int errors = 0;
  int cur_idx = -1;
  bit live = 1'b0;
  bit done = 1'b0;

  logic [7:0]  tx_exp[$];
  logic [12:0] wr_exp[$];

  always #4 clk = ~clk;

  ts0_ctrl_link uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .ser_in(ser_in), .ser_out(ser_out), .alarm_set(alarm_set),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive one bit time and sample the output after its strobe
  task automatic run_bit(input int idx, input logic b, output logic s);
    @(negedge clk);
    cur_idx     = idx;
    bit_en      = 1'b1;
    frame_start = (idx == 0);
    ser_in      = b;
    @(negedge clk);
    s           = ser_out;
    bit_en      = 1'b0;
    frame_start = 1'b0;
  endtask

  // one frame: slot byte in, slot byte out compared with the scoreboard
  task automatic run_frame(input logic [7:0] rx_b);
    logic [7:0] got;
    logic [7:0] exp;
    logic       s;
    got = '0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      run_bit(i, (i < 8) ? rx_b[7-i] : 1'($urandom), s);
      if (i < 8) got[7-i] = s;
      if (i == 7) begin
        exp = (tx_exp.size() != 0) ? tx_exp.pop_front() : 8'hFF;
        check(got == exp, "R7/R8/R9/R10 slot byte", got, exp);
      end
      if (i == 8 || i == 200) check(s == 1'b1, "R6 output high outside slot", s, 1);
    end
  endtask

  task automatic send_write(input logic [5:0] a, input logic [6:0] d);
    run_frame({2'b00, a});
    wr_exp.push_back({a, d});
    run_frame({1'b1, d});
  endtask

  task automatic raise(input logic [6:0] mask, input bit push);
    @(negedge clk);
    alarm_set = mask;
    @(negedge clk);
    alarm_set = '0;
    if (push) begin
      for (int i = 0; i < 7; i++) begin
        if (mask[i]) begin
          tx_exp.push_back(HEAD);
          tx_exp.push_back(8'h80 | (8'h01 << i));
        end
      end
    end
  endtask

  // scoreboard monitor for writes
  always @(negedge clk) begin
    if (live && wr_stb) begin
      if (wr_exp.size() == 0) begin
        check(1'b0, "R4 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [12:0] e;
        e = wr_exp.pop_front();
        check({wr_addr, wr_data} == e, "R3 write address/data", {wr_addr, wr_data}, e);
        check(cur_idx == 7, "R3 strobe after last slot bit", cur_idx, 7);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ser_out == 1'b1, "R11 ser_out in reset", ser_out, 1);
    check(wr_stb == 1'b0, "R11 wr_stb in reset", wr_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;
    check(ser_out == 1'b1, "R11 ser_out after reset", ser_out, 1);
    check(wr_stb == 1'b0, "R11 wr_stb after reset", wr_stb, 0);

    // R9 idle and R1 basic write
    run_frame(8'hFF);
    send_write(6'h12, 7'h55);
    // R2 bit 6 of address byte ignored
    run_frame(8'h6A);
    wr_exp.push_back({6'h2A, 7'h00});
    run_frame(8'h80);
    // R4 lone data bytes discarded
    run_frame(8'hC3);
    run_frame(8'hFF);
    // R5 second address replaces first
    run_frame(8'h05);
    run_frame(8'h3F);
    wr_exp.push_back({6'h3F, 7'h7F});
    run_frame(8'hFF);
    send_write(6'h00, 7'h01);
    // R4 repeated data byte after completed write
    run_frame(8'h10);
    wr_exp.push_back({6'h10, 7'h10});
    run_frame(8'h90);
    run_frame(8'h91);
    check(wr_exp.size() == 0, "R3/R4 writes all seen", wr_exp.size(), 0);

    // R7/R8 several alarms, lowest first, with receive traffic alongside
    raise(7'b010_1001, 1'b1);
    send_write(6'h21, 7'h2B);
    for (int k = 0; k < 5; k++) run_frame(8'hFF);
    run_frame(8'hFF);  // R9 idle again
    check(tx_exp.size() == 0, "R8 alarm stream drained", tx_exp.size(), 0);

    // R12 raising a pending alarm twice yields one message
    raise(7'b001_0000, 1'b1);
    raise(7'b001_0000, 1'b0);
    for (int k = 0; k < 3; k++) run_frame(8'hFF);

    // R8 lower alarm raised mid-message waits for the message to finish
    raise(7'b110_0000, 1'b1);
    run_frame(8'hFF);  // head for 5
    raise(7'b000_0010, 1'b0);
    tx_exp.insert(1, HEAD);
    tx_exp.insert(2, 8'h82);
    for (int k = 0; k < 6; k++) run_frame(8'hFF);
    check(tx_exp.size() == 0, "R8 mid-message ordering drained", tx_exp.size(), 0);
    check(wr_exp.size() == 0, "R3 final writes seen", wr_exp.size(), 0);

    done = 1'b1;
    summary();
  end
endmodule